// File: doc/BRIEF.md
# Overlay-Mapped Control Register Bank

This block is the register file a small microcontroller sees over a plain parallel bus: an address, a byte of write data, a write strobe, a read strobe and a registered read-data byte. The address space holds sixteen byte registers and eight nibble registers. Three select bits, kept in byte register 15, remap parts of the byte space while they are set. One bit swaps the low byte addresses for a second bank of plain storage. One bit turns address 12 into a data port toward a D-channel path. One bit turns address 13 into a byte port toward a dump/restore path. Registers that an overlay hides keep their contents and appear again once the select bit clears.

Byte register 11 is split. Writes hold activation control: seven control bits and a timer-disable bit, driven straight out on ports. Reads return live status: seven activation-state bits and a timer-expired flag, taken from input ports. A readback bit in byte register 14 makes reads of register 11 return the stored control byte instead. A self-clearing software reset bit in nibble register 0 clears the control byte and leaves the select bits alone.

Top module: `ovl_regbank`

## Requirements
- R1: After hardware reset (rstN low), every byte, overlay and nibble register is zero, rdData is zero, and actCtrl, timerDisable, overlaySel, dchSel, dumpSel, dchTxStb, dumpWrStb and dumpRdStb are all low.
- R2: Address bit 4 = 0 selects byte register addr[3:0]. Address bit 4 = 1 with bit 3 = 0 selects nibble register addr[2:0], which stores wrData[3:0] and reads back as {4'b0, value}. Addresses 0x18 to 0x1F ignore writes and read as zero.
- R3: While bit 0 of byte register 15 (overlaySel) is set, byte addresses 0 to 9 read and write a separate overlay bank. Addresses 10 to 15 are unaffected. The hidden normal registers keep their values and read back unchanged after the bit clears.
- R4: While bit 1 of byte register 15 (dchSel) is set, a write to byte address 12 places the byte on dchTxData, with dchTxStb high for the following cycle. A read returns dchRxData. Normal register 12 is left unchanged.
- R5: While bit 2 of byte register 15 (dumpSel) is set, a write to byte address 13 places the byte on dumpWrData, with dumpWrStb high for the following cycle. A read returns dumpRdData, with dumpRdStb high in the cycle rdData updates. Normal register 13 is left unchanged.
- R6: A write to byte address 11 drives wrData[7:1] on actCtrl and wrData[0] on timerDisable from the next cycle. A read of address 11 returns {actState, timerExpired}.
- R7: While bit 6 of byte register 14 is set, a read of byte address 11 returns the stored control byte instead of the status.
- R8: Writing a 1 to bit 3 of nibble register 0 clears the address-11 control byte on the following clock. The bit then clears itself and reads back as 0. The other nibble-0 bits, the select bits in register 15 and all other registers are unchanged.
- R9: rdData takes its new value on the clock edge where rdEn is sampled high, and holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| addr | input | 5 | Register address; bit 4 selects nibble space |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| actState | input | 7 | Activation state reported through register 11 |
| timerExpired | input | 1 | Timer-expired flag reported through register 11 |
| actCtrl | output | 7 | Stored activation control bits |
| timerDisable | output | 1 | Stored timer-disable bit |
| overlaySel | output | 1 | Overlay bank select in force |
| dchSel | output | 1 | D-channel port select in force |
| dumpSel | output | 1 | Dump port select in force |
| dchTxData | output | 8 | Last byte written to the D-channel port |
| dchTxStb | output | 1 | One-cycle pulse after a D-channel port write |
| dchRxData | input | 8 | Received D-channel byte returned on port reads |
| dumpWrData | output | 8 | Last byte written to the dump port |
| dumpWrStb | output | 1 | One-cycle pulse after a dump port write |
| dumpRdData | input | 8 | Byte returned on dump port reads |
| dumpRdStb | output | 1 | Pulse marking a dump port read |

## Verification
The hardest situation to reach is a software reset that lands while an overlay and the readback mode are both active. The check must show that the control byte is gone, while the select bits, the readback bit and the hidden normal registers survive. The bench reaches it by writing known values into the normal registers first, then setting the overlay and readback bits, then issuing the reset through nibble register 0. It waits one idle cycle for the clear, and finally reads back every affected location through the bus and the control ports.

// File: rtl/ovlregs_pkg.sv
package ovlregs_pkg;
  localparam int DW        = 8;
  localparam int NW        = 4;
  localparam int BYTE_REGS = 16;
  localparam int OVL_REGS  = 10;
  localparam int NIB_REGS  = 8;
  localparam int BIDXW     = $clog2(BYTE_REGS);
  localparam int NIDXW     = $clog2(NIB_REGS);
  localparam int AW        = BIDXW + 1;
  localparam int CTRLW     = DW - 1;

  // byte register roles
  localparam int CTRL_IDX = 11;
  localparam int DCH_IDX  = 12;
  localparam int DUMP_IDX = 13;
  localparam int RBK_IDX  = 14;
  localparam int SEL_IDX  = 15;

  // bit positions
  localparam int RBK_BIT      = 6;
  localparam int SWRST_BIT    = 3;
  localparam int SEL_OVL_BIT  = 0;
  localparam int SEL_DCH_BIT  = 1;
  localparam int SEL_DUMP_BIT = 2;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_NORM, SRC_OVL, SRC_NIB, SRC_STAT, SRC_CTRL, SRC_DCH, SRC_DUMP
  } rdSrc_e;

  typedef struct packed {
    logic [BYTE_REGS-1:0] normWr;
    logic [OVL_REGS-1:0]  ovlWr;
    logic [NIB_REGS-1:0]  nibWr;
    logic                 dchWr;
    logic                 dumpWr;
    logic                 rdStb;
    rdSrc_e               rdSrc;
    logic [BIDXW-1:0]     idx;
  } regStb_t;
endpackage

// File: rtl/ovlreg_decode.sv
module ovlreg_decode
  import ovlregs_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          overlaySel,
  input  logic          dchSel,
  input  logic          dumpSel,
  input  logic          rbkEn,
  output regStb_t       stb
);
  logic [BIDXW-1:0] byteIdx;
  logic             nibSpace;
  logic             nibMapped;
  logic             inOvlRange;

  assign byteIdx    = addr[BIDXW-1:0];
  assign nibSpace   = addr[AW-1];
  assign nibMapped  = (addr[BIDXW-1:NIDXW] == '0);
  assign inOvlRange = (int'(byteIdx) < OVL_REGS);

  always_comb begin
    stb       = '0;
    stb.rdStb = rdEn;
    stb.idx   = byteIdx;
    stb.rdSrc = SRC_ZERO;
    if (nibSpace) begin
      if (nibMapped) begin
        stb.rdSrc = SRC_NIB;
        for (int j = 0; j < NIB_REGS; j++)
          if (int'(addr[NIDXW-1:0]) == j) stb.nibWr[j] = wrEn;
      end
    end else if (overlaySel && inOvlRange) begin
      stb.rdSrc = SRC_OVL;
      for (int k = 0; k < OVL_REGS; k++)
        if (int'(byteIdx) == k) stb.ovlWr[k] = wrEn;
    end else if (dchSel && int'(byteIdx) == DCH_IDX) begin
      stb.rdSrc = SRC_DCH;
      stb.dchWr = wrEn;
    end else if (dumpSel && int'(byteIdx) == DUMP_IDX) begin
      stb.rdSrc  = SRC_DUMP;
      stb.dumpWr = wrEn;
    end else begin
      if (int'(byteIdx) == CTRL_IDX) stb.rdSrc = rbkEn ? SRC_CTRL : SRC_STAT;
      else                           stb.rdSrc = SRC_NORM;
      for (int i = 0; i < BYTE_REGS; i++)
        if (int'(byteIdx) == i) stb.normWr[i] = wrEn;
    end
  end
endmodule

// File: rtl/ovlreg_store.sv
module ovlreg_store
  import ovlregs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [DW-1:0]    wrData,
  input  logic [CTRLW-1:0] actState,
  input  logic             timerExpired,
  input  logic [DW-1:0]    dchRxData,
  input  logic [DW-1:0]    dumpRdData,
  output logic [DW-1:0]    rdData,
  output logic             overlaySel,
  output logic             dchSel,
  output logic             dumpSel,
  output logic             rbkEn,
  output logic             swRstPend,
  output logic [CTRLW-1:0] actCtrl,
  output logic             timerDisable,
  output logic [DW-1:0]    dchTxData,
  output logic             dchTxStb,
  output logic [DW-1:0]    dumpWrData,
  output logic             dumpWrStb,
  output logic             dumpRdStb
);
  logic [BYTE_REGS-1:0][DW-1:0] normMem;
  logic [OVL_REGS-1:0][DW-1:0]  ovlMem;
  logic [NIB_REGS-1:0][NW-1:0]  nibMem;
  logic [DW-1:0]                ovlRd;
  logic [DW-1:0]                rdNext;

  // normal byte bank; only the control byte obeys software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) normMem <= '0;
    else begin
      for (int i = 0; i < BYTE_REGS; i++) begin
        if (i == CTRL_IDX && swRstPend) normMem[i] <= '0;
        else if (stb.normWr[i])         normMem[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovlMem <= '0;
    else
      for (int k = 0; k < OVL_REGS; k++)
        if (stb.ovlWr[k]) ovlMem[k] <= wrData;
  end

  // nibble bank with a self-clearing reset request bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nibMem <= '0;
    else begin
      if (swRstPend) nibMem[0][SWRST_BIT] <= 1'b0;
      for (int j = 0; j < NIB_REGS; j++)
        if (stb.nibWr[j]) nibMem[j] <= wrData[NW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dchTxData  <= '0;
      dchTxStb   <= 1'b0;
      dumpWrData <= '0;
      dumpWrStb  <= 1'b0;
      dumpRdStb  <= 1'b0;
    end else begin
      dchTxStb  <= stb.dchWr;
      dumpWrStb <= stb.dumpWr;
      dumpRdStb <= stb.rdStb && (stb.rdSrc == SRC_DUMP);
      if (stb.dchWr)  dchTxData  <= wrData;
      if (stb.dumpWr) dumpWrData <= wrData;
    end
  end

  always_comb begin
    ovlRd = '0;
    for (int k = 0; k < OVL_REGS; k++)
      if (int'(stb.idx) == k) ovlRd = ovlMem[k];
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_NORM: rdNext = normMem[stb.idx];
      SRC_OVL:  rdNext = ovlRd;
      SRC_NIB:  rdNext = {{(DW-NW){1'b0}}, nibMem[stb.idx[NIDXW-1:0]]};
      SRC_STAT: rdNext = {actState, timerExpired};
      SRC_CTRL: rdNext = normMem[CTRL_IDX];
      SRC_DCH:  rdNext = dchRxData;
      SRC_DUMP: rdNext = dumpRdData;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  assign overlaySel   = normMem[SEL_IDX][SEL_OVL_BIT];
  assign dchSel       = normMem[SEL_IDX][SEL_DCH_BIT];
  assign dumpSel      = normMem[SEL_IDX][SEL_DUMP_BIT];
  assign rbkEn        = normMem[RBK_IDX][RBK_BIT];
  assign swRstPend    = nibMem[0][SWRST_BIT];
  assign actCtrl      = normMem[CTRL_IDX][DW-1:1];
  assign timerDisable = normMem[CTRL_IDX][0];
endmodule

// File: rtl/ovl_regbank.sv
module ovl_regbank
  import ovlregs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wrData,
  input  logic             wrEn,
  input  logic             rdEn,
  output logic [DW-1:0]    rdData,
  input  logic [CTRLW-1:0] actState,
  input  logic             timerExpired,
  output logic [CTRLW-1:0] actCtrl,
  output logic             timerDisable,
  output logic             overlaySel,
  output logic             dchSel,
  output logic             dumpSel,
  output logic [DW-1:0]    dchTxData,
  output logic             dchTxStb,
  input  logic [DW-1:0]    dchRxData,
  output logic [DW-1:0]    dumpWrData,
  output logic             dumpWrStb,
  input  logic [DW-1:0]    dumpRdData,
  output logic             dumpRdStb
);
  regStb_t stb;
  logic    rbkEn;
  logic    swRstPend;

  ovlreg_decode u_decode (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .overlaySel(overlaySel), .dchSel(dchSel), .dumpSel(dumpSel),
    .rbkEn(rbkEn), .stb(stb)
  );

  ovlreg_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .actState(actState), .timerExpired(timerExpired),
    .dchRxData(dchRxData), .dumpRdData(dumpRdData),
    .rdData(rdData), .overlaySel(overlaySel), .dchSel(dchSel),
    .dumpSel(dumpSel), .rbkEn(rbkEn), .swRstPend(swRstPend),
    .actCtrl(actCtrl), .timerDisable(timerDisable),
    .dchTxData(dchTxData), .dchTxStb(dchTxStb),
    .dumpWrData(dumpWrData), .dumpWrStb(dumpWrStb), .dumpRdStb(dumpRdStb)
  );
endmodule

// File: rtl/ovl_regbank_chk.sv
module ovl_regbank_chk
  import ovlregs_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wrData,
  input logic             wrEn,
  input logic             rdEn,
  input logic [DW-1:0]    rdData,
  input logic [CTRLW-1:0] actCtrl,
  input logic             timerDisable,
  input logic             overlaySel,
  input logic             dchSel,
  input logic             dumpSel,
  input logic [DW-1:0]    dchTxData,
  input logic             dchTxStb,
  input logic [DW-1:0]    dumpWrData,
  input logic             dumpWrStb,
  input logic             swRstPend
);
  localparam logic [AW-1:0] CtrlAddr = AW'(CTRL_IDX);
  localparam logic [AW-1:0] DchAddr  = AW'(DCH_IDX);
  localparam logic [AW-1:0] DumpAddr = AW'(DUMP_IDX);
  localparam logic [AW-1:0] SelAddr  = AW'(SEL_IDX);
  localparam logic [AW-1:0] Nib0Addr = AW'(BYTE_REGS);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R6
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CtrlAddr && !swRstPend) |=> ({actCtrl, timerDisable} == $past(wrData)));

  // R8
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == Nib0Addr && wrData[SWRST_BIT]) |=> ##1 (actCtrl == '0 && !timerDisable));

  // R8
  swrst_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swRstPend && !(wrEn && addr == SelAddr)) |=> $stable({overlaySel, dchSel, dumpSel}));

  // R4
  dch_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == DchAddr && dchSel) |=> (dchTxStb && dchTxData == $past(wrData)));

  // R5
  dump_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == DumpAddr && dumpSel) |=> (dumpWrStb && dumpWrData == $past(wrData)));
endmodule

bind ovl_regbank ovl_regbank_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .actCtrl(actCtrl), .timerDisable(timerDisable),
  .overlaySel(overlaySel), .dchSel(dchSel), .dumpSel(dumpSel),
  .dchTxData(dchTxData), .dchTxStb(dchTxStb), .dumpWrData(dumpWrData),
  .dumpWrStb(dumpWrStb), .swRstPend(swRstPend)
);

// File: tb/ovl_regbank_test.sv
module ovl_regbank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [6:0] actState = '0;
  logic       timerExpired = 1'b0;
  logic [6:0] actCtrl;
  logic       timerDisable, overlaySel, dchSel, dumpSel;
  logic [7:0] dchTxData, dumpWrData;
  logic       dchTxStb, dumpWrStb, dumpRdStb;
  logic [7:0] dchRxData = '0;
  logic [7:0] dumpRdData = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ovl_regbank uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .actState(actState), .timerExpired(timerExpired),
    .actCtrl(actCtrl), .timerDisable(timerDisable), .overlaySel(overlaySel),
    .dchSel(dchSel), .dumpSel(dumpSel), .dchTxData(dchTxData), .dchTxStb(dchTxStb),
    .dchRxData(dchRxData), .dumpWrData(dumpWrData), .dumpWrStb(dumpWrStb),
    .dumpRdData(dumpRdData), .dumpRdStb(dumpRdStb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    chk("R1 rdData", rdData, 0);
    chk("R1 outputs", {actCtrl, timerDisable, overlaySel, dchSel, dumpSel,
        dchTxStb, dumpWrStb, dumpRdStb}, 0);
    rd(5'd5, v);  chk("R1 byte5", v, 0);
    rd(5'h13, v); chk("R1 nib3", v, 0);
  endtask

  task automatic test_normal();
    logic [7:0] v;
    wr(5'd3, 8'hA5); wr(5'd10, 8'h3C); wr(5'd12, 8'h11); wr(5'd13, 8'h22);
    wr(5'h12, 8'hF7); wr(5'h18, 8'hFF);
    rd(5'd3, v);  chk("R2 byte3", v, 8'hA5);
    rd(5'd10, v); chk("R2 byte10", v, 8'h3C);
    rd(5'h12, v); chk("R2 nib2 upper zero", v, 8'h07);
    rd(5'h18, v); chk("R2 unmapped nibble", v, 8'h00);
  endtask

  task automatic test_overlay();
    logic [7:0] v;
    wr(5'd15, 8'h01);
    chk("R3 overlaySel", overlaySel, 1);
    rd(5'd3, v);  chk("R3 overlay starts zero", v, 0);
    wr(5'd3, 8'h5A);
    rd(5'd3, v);  chk("R3 overlay write", v, 8'h5A);
    rd(5'd10, v); chk("R3 byte10 unaffected", v, 8'h3C);
    wr(5'd15, 8'h00);
    rd(5'd3, v);  chk("R3 hidden reg kept", v, 8'hA5);
  endtask

  task automatic test_dch();
    logic [7:0] v;
    wr(5'd15, 8'h02);
    dchRxData = 8'h99;
    wr(5'd12, 8'h77);
    chk("R4 dchTxStb", dchTxStb, 1);
    chk("R4 dchTxData", dchTxData, 8'h77);
    @(negedge clk);
    chk("R4 dchTxStb one cycle", dchTxStb, 0);
    rd(5'd12, v); chk("R4 dch read", v, 8'h99);
    wr(5'd15, 8'h00);
    rd(5'd12, v); chk("R4 normal reg12 kept", v, 8'h11);
  endtask

  task automatic test_dump();
    logic [7:0] v;
    wr(5'd15, 8'h04);
    dumpRdData = 8'hC3;
    rd(5'd13, v);
    chk("R5 dump read", v, 8'hC3);
    chk("R5 dumpRdStb", dumpRdStb, 1);
    wr(5'd13, 8'h4E);
    chk("R5 dumpWrStb", dumpWrStb, 1);
    chk("R5 dumpWrData", dumpWrData, 8'h4E);
    wr(5'd15, 8'h00);
    chk("R5 dumpWrStb drops", dumpWrStb, 0);
    rd(5'd13, v); chk("R5 normal reg13 kept", v, 8'h22);
  endtask

  task automatic test_split();
    logic [7:0] v;
    actState = 7'h55; timerExpired = 1'b1;
    wr(5'd11, 8'hB3);
    chk("R6 actCtrl", actCtrl, 7'h59);
    chk("R6 timerDisable", timerDisable, 1);
    rd(5'd11, v); chk("R6 status read", v, 8'hAB);
  endtask

  task automatic test_readback();
    logic [7:0] v;
    wr(5'd14, 8'h40);
    rd(5'd11, v); chk("R7 readback on", v, 8'hB3);
    wr(5'd14, 8'h00);
    rd(5'd11, v); chk("R7 readback off", v, 8'hAB);
  endtask

  task automatic test_swreset();
    logic [7:0] v;
    wr(5'd15, 8'h01);
    wr(5'd14, 8'h40);
    wr(5'h10, 8'h0D);
    @(negedge clk);
    chk("R8 control cleared", {actCtrl, timerDisable}, 0);
    chk("R8 overlaySel kept", overlaySel, 1);
    rd(5'h10, v);  chk("R8 bit self-clears", v, 8'h05);
    rd(5'd11, v);  chk("R8 readback zero", v, 8'h00);
    rd(5'd14, v);  chk("R8 reg14 kept", v, 8'h40);
    rd(5'd3, v);   chk("R8 overlay kept", v, 8'h5A);
    wr(5'd15, 8'h00);
    rd(5'd3, v);   chk("R8 normal kept", v, 8'hA5);
  endtask

  task automatic test_latency();
    logic [7:0] v;
    rd(5'd10, v);
    addr = 5'd3;
    repeat (3) @(negedge clk);
    chk("R9 rdData holds", rdData, 8'h3C);
    @(negedge clk);
    addr = 5'd3; rdEn = 1'b1;
    chk("R9 not before edge", rdData, 8'h3C);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 after edge", rdData, 8'hA5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_normal();
    test_overlay();
    test_dch();
    test_dump();
    test_split();
    test_readback();
    test_swreset();
    test_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule